// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block joins a fast 16-bit narrow port (A) to a slower 32-bit wide port built from two 16-bit halves, called the low half and the high half. Every transfer is synchronous to a single clock. A select input tells the block which half of the wide word is being handled on each edge.

When data moves from narrow to wide, two narrow words in a row become one wide word. The first word, taken on an edge with select high, is held in a staging register. On the following edge with select low, the staged word and the word present on A are loaded into the low and high halves together. When data moves from wide to narrow, the process runs the other way. On an edge with select low, the A output takes the low half and the high half is parked in a register. On the next edge with select high, the parked high half is placed on A.

A separate 2-bit mask lane pair follows the same narrow-to-wide staging, whatever the direction. Direction is a registered control. An active-low output enable gates the three tri-state enables, which are brought out as separate enable signals beside the data outputs.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears every data output to zero and sets the registered direction to wide-to-narrow (value 0). While `oe_n` is 1, all three enables (`a_oe`, `b_oe`, `d_oe`) are 0.
- R2: Narrow-to-wide, registered direction 1: on an edge with `sel`=1, `a_in` is captured into the staging register, and `b_lo_out` and `b_hi_out` keep their values.
- R3: Narrow-to-wide, registered direction 1: on an edge with `sel`=0, `b_lo_out` takes the word staged at the last `sel`=1 edge and `b_hi_out` takes the current `a_in`. Both halves change on this same edge.
- R4: Wide-to-narrow, registered direction 0: on an edge with `sel`=0, `a_out` takes `b_lo_in` and `b_hi_in` is parked. On an edge with `sel`=1, `a_out` takes the parked word, not the current `b_hi_in`.
- R5: `dir_ab` is sampled on the rising edge. The enables change on the edge that samples a new value, never before it.
- R6: With `oe_n`=0, registered direction 1 gives `b_oe`=1 and `a_oe`=0. Registered direction 0 gives `a_oe`=1 and `b_oe`=0. `a_oe` and `b_oe` are never both 1.
- R7: The mask lanes `c_in` feed `d_lo_out` and `d_hi_out` with the same staging as R2 and R3, in either direction.
- R8: The registers of the direction not currently registered hold their values. `b_lo_out` and `b_hi_out` do not change while the registered direction is 0, and `a_out` does not change while it is 1.
- R9: `d_oe` equals the inverse of `oe_n`, whatever the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir_ab | input | 1 | Direction request: 1 narrow-to-wide, 0 wide-to-narrow |
| sel | input | 1 | Half select for staging |
| a_in | input | 16 | Narrow port input data |
| a_out | output | 16 | Narrow port output data |
| a_oe | output | 1 | Narrow port drive enable |
| b_lo_in | input | 16 | Wide port low half input |
| b_hi_in | input | 16 | Wide port high half input |
| b_lo_out | output | 16 | Wide port low half output |
| b_hi_out | output | 16 | Wide port high half output |
| b_oe | output | 1 | Wide port drive enable |
| c_in | input | 2 | Mask lane input |
| d_lo_out | output | 2 | Mask lane low output |
| d_hi_out | output | 2 | Mask lane high output |
| d_oe | output | 1 | Mask lane drive enable |

## Verification
The narrow-to-wide tests stream pairs of distinct narrow words. Because the two words always differ, a low and high half loaded in swapped order shows up, and so does a half loaded one edge early. For wide-to-narrow, the high-half input is changed between the two edges, which separates a parked high half from a live one. Direction is toggled with the enables sampled before and after the edge, and with the output enable deasserted, to show the one-edge lag. It also shows that the mask enable ignores direction.

// File: rtl/bx_pkg.sv
package bx_pkg;
    localparam int NARROW_W = 16;
    localparam int MASK_W   = 2;

    typedef enum logic {
        DIR_W2N = 1'b0,
        DIR_N2W = 1'b1
    } dir_e;

    typedef struct packed {
        logic narrow;
        logic wide;
        logic mask;
    } drive_t;

    function automatic drive_t decode_drive(input logic oe_n, input dir_e d);
        drive_t r;
        r.narrow = !oe_n && (d == DIR_W2N);
        r.wide   = !oe_n && (d == DIR_N2W);
        r.mask   = !oe_n;
        return r;
    endfunction
endpackage

// File: rtl/bx_turn.sv
module bx_turn
    import bx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dir_req,
    input  logic   oe_n,
    output dir_e   dir_q,
    output drive_t drive
);
    always_ff @(posedge clk) begin
        if (rst) dir_q <= DIR_W2N;
        else     dir_q <= dir_e'(dir_req);
    end

    assign drive = decode_drive(oe_n, dir_q);

    // R5: registered direction follows the request one edge later
    a_r5_dir_lag: assert property (@(posedge clk) disable iff (rst)
        (dir_req != dir_q) |=> (dir_q == $past(dir_e'(dir_req))));

    // R6: never both ports driving
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(drive.narrow && drive.wide));
endmodule

// File: rtl/bx_widen.sv
module bx_widen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q
);
    logic [W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (en) begin
            if (sel) begin
                stage_q <= din;
            end else begin
                lo_q <= stage_q;
                hi_q <= din;
            end
        end
    end

    // R2: an edge with sel high leaves both wide halves untouched
    a_r2_hold_on_sel_high: assert property (@(posedge clk) disable iff (rst)
        (en && sel) |=> ($stable(lo_q) && $stable(hi_q)));

    // R3: the high half takes the live word on a sel-low edge
    a_r3_hi_live: assert property (@(posedge clk) disable iff (rst)
        (en && !sel) |=> (hi_q == $past(din)));

    // R8: idle path holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/bx_narrow.sv
module bx_narrow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sel,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] hi_in,
    output logic [W-1:0] dout
);
    logic [W-1:0] park_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            park_q <= '0;
            dout   <= '0;
        end else if (en) begin
            if (sel) begin
                dout <= park_q;
            end else begin
                park_q <= hi_in;
                dout   <= lo_in;
            end
        end
    end

    // R4: the low half reaches the narrow output on a sel-low edge
    a_r4_lo_first: assert property (@(posedge clk) disable iff (rst)
        (en && !sel) |=> (dout == $past(lo_in)));

    // R8: idle path holds
    a_r8_narrow_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
    import bx_pkg::*;
#(
    parameter int DW = NARROW_W,
    parameter int MW = MASK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          oe_n,
    input  logic          dir_ab,
    input  logic          sel,
    input  logic [DW-1:0] a_in,
    output logic [DW-1:0] a_out,
    output logic          a_oe,
    input  logic [DW-1:0] b_lo_in,
    input  logic [DW-1:0] b_hi_in,
    output logic [DW-1:0] b_lo_out,
    output logic [DW-1:0] b_hi_out,
    output logic          b_oe,
    input  logic [MW-1:0] c_in,
    output logic [MW-1:0] d_lo_out,
    output logic [MW-1:0] d_hi_out,
    output logic          d_oe
);
    dir_e   dir_q;
    drive_t drive;

    bx_turn u_turn (
        .clk     (clk),
        .rst     (rst),
        .dir_req (dir_ab),
        .oe_n    (oe_n),
        .dir_q   (dir_q),
        .drive   (drive)
    );

    bx_widen #(.W(DW)) u_data_widen (
        .clk  (clk),
        .rst  (rst),
        .en   (dir_q == DIR_N2W),
        .sel  (sel),
        .din  (a_in),
        .lo_q (b_lo_out),
        .hi_q (b_hi_out)
    );

    bx_widen #(.W(MW)) u_mask_widen (
        .clk  (clk),
        .rst  (rst),
        .en   (1'b1),
        .sel  (sel),
        .din  (c_in),
        .lo_q (d_lo_out),
        .hi_q (d_hi_out)
    );

    bx_narrow #(.W(DW)) u_data_narrow (
        .clk   (clk),
        .rst   (rst),
        .en    (dir_q == DIR_W2N),
        .sel   (sel),
        .lo_in (b_lo_in),
        .hi_in (b_hi_in),
        .dout  (a_out)
    );

    assign a_oe = drive.narrow;
    assign b_oe = drive.wide;
    assign d_oe = drive.mask;

    // R1: with output enable released nothing drives
    a_r1_released: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !(a_oe || b_oe || d_oe));

    // R9: mask enable tracks the output enable only
    a_r9_mask_oe: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> d_oe);
endmodule

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        oe_n = 1'b1;
    logic        dir_ab = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] a_in = '0, b_lo_in = '0, b_hi_in = '0;
    logic [1:0]  c_in = '0;
    logic [15:0] a_out, b_lo_out, b_hi_out;
    logic [1:0]  d_lo_out, d_hi_out;
    logic        a_oe, b_oe, d_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bus_exchanger u_dut (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir_ab(dir_ab), .sel(sel),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_lo_in(b_lo_in), .b_hi_in(b_hi_in),
        .b_lo_out(b_lo_out), .b_hi_out(b_hi_out), .b_oe(b_oe),
        .c_in(c_in), .d_lo_out(d_lo_out), .d_hi_out(d_hi_out), .d_oe(d_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; oe_n = 1'b1; dir_ab = 1'b0;
        tick(); tick();
        rst = 1'b0;
        #1;
        check("R1 a_out", 32'(a_out), 0);
        check("R1 b halves", {b_hi_out, b_lo_out}, 0);
        check("R1 mask", 32'({d_hi_out, d_lo_out}), 0);
        check("R1 enables", 32'({a_oe, b_oe, d_oe}), 0);
        oe_n = 1'b0; #1;
        check("R6 w2n enables", 32'({a_oe, b_oe, d_oe}), 32'b101);
    endtask

    task automatic t_turn_to_n2w();
        dir_ab = 1'b1; #1;
        check("R5 before edge", 32'({a_oe, b_oe}), 32'b10);
        tick();
        check("R5 after edge", 32'({a_oe, b_oe}), 32'b01);
        check("R6 n2w enables", 32'({a_oe, b_oe, d_oe}), 32'b011);
    endtask

    task automatic t_widen_stream();
        logic [15:0] a_hold;
        a_hold = a_out;
        for (int i = 0; i < 4; i++) begin
            logic [15:0] w0, w1, lo0, hi0;
            w0 = 16'h1000 + 16'(i * 16'h0111);
            w1 = 16'hA000 ^ 16'(i * 16'h0123);
            lo0 = b_lo_out; hi0 = b_hi_out;
            sel = 1'b1; a_in = w0; c_in = 2'(i);
            tick();
            check("R2 halves hold", {b_hi_out, b_lo_out}, {hi0, lo0});
            sel = 1'b0; a_in = w1; c_in = 2'(~i);
            tick();
            check("R3 pair", {b_hi_out, b_lo_out}, {w1, w0});
            check("R7 mask pair", 32'({d_hi_out, d_lo_out}), 32'({2'(~i), 2'(i)}));
        end
        check("R8 a_out idle", 32'(a_out), 32'(a_hold));
    endtask

    task automatic t_turn_to_w2n();
        logic [15:0] lo0, hi0;
        sel = 1'b1; a_in = 16'h5A5A; dir_ab = 1'b0;
        tick();
        check("R5 turn edge", 32'({a_oe, b_oe}), 32'b10);
        lo0 = b_lo_out; hi0 = b_hi_out;
        sel = 1'b0; a_in = 16'h3C3C;
        tick();
        check("R8 b idle", {b_hi_out, b_lo_out}, {hi0, lo0});
    endtask

    task automatic t_narrow_stream();
        for (int i = 0; i < 3; i++) begin
            logic [15:0] lo, hi;
            lo = 16'hAA00 + 16'(i);
            hi = 16'hBB00 + 16'(i);
            sel = 1'b0; b_lo_in = lo; b_hi_in = hi; c_in = 2'b01;
            tick();
            check("R4 low first", 32'(a_out), 32'(lo));
            sel = 1'b1; b_hi_in = 16'hCCCC; b_lo_in = 16'hDDDD; c_in = 2'b10;
            tick();
            check("R4 parked high", 32'(a_out), 32'(hi));
        end
        sel = 1'b0; c_in = 2'b11;
        tick();
        check("R7 mask in w2n", 32'({d_hi_out, d_lo_out}), 32'b1110);
    endtask

    task automatic t_released();
        oe_n = 1'b1; dir_ab = 1'b1; #1;
        check("R9 oe high", 32'({a_oe, b_oe, d_oe}), 0);
        tick();
        check("R6 oe high after turn", 32'({a_oe, b_oe, d_oe}), 0);
        oe_n = 1'b0; #1;
        check("R9 mask oe", 32'(d_oe), 1);
    endtask

    initial begin
        t_reset();
        t_turn_to_n2w();
        t_widen_stream();
        t_turn_to_w2n();
        t_narrow_stream();
        t_released();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule